// File: doc/BRIEF.md
# Serial-In Latched Parallel Output Driver Core

This block is the digital core of a serial-input, parallel-output display driver. On every rising clock edge one bit enters a chain of storage stages. The bit loaded first ends up in the stage furthest from the input once the chain is full. The stage at the far end of the chain drives a serial output. Several cores can therefore be cascaded, with each core's serial output feeding the next core's serial input.

A bank of level-sensitive latches sits between the stages and the parallel outputs. While the strobe input is high the latches are transparent and follow the stages. While it is low they keep their contents, whatever the clock and data inputs do. A blanking input forces every parallel output low and leaves the latch contents untouched. When blanking is released, the outputs show the held data again.

The latches can be bypassed by holding the strobe high permanently. In that mode, blanking must stay high while data is being loaded so that the shifting data never reaches the outputs. An active-low asynchronous reset clears the stages and the latches.

Top module: `serial_latch_driver`

## Requirements
- R1: While rst_ni is low, every stage and every latch is zero, so drive_o is all zeros and sdata_o is 0. This also holds when reset is asserted in the middle of operation.
- R2: On each rising edge of clk_i, sdata_i is stored in stage 0 (drive_o[0]), and stage k moves to stage k+1. After Width edges, the first bit loaded sits in stage Width-1.
- R3: sdata_o always equals stage Width-1, so a bit reaches sdata_o Width edges after it is loaded. When two cores are chained, a bit reaches the second core's sdata_o after 2*Width edges.
- R4: While strobe_i is high and blank_i is low, drive_o equals the current stage contents and follows every shift without waiting for a further strobe edge.
- R5: While strobe_i is low, the latch contents do not change, whatever clk_i and sdata_i do.
- R6: While blank_i is high, drive_o is all zeros, whatever the latch contents.
- R7: blank_i has no effect on the latch contents. A strobe that occurs while blank_i is high still loads the latches, and when blank_i falls drive_o shows the latched data.
- R8: With strobe_i held high and blank_i held high during a full load, drive_o stays all zeros in every cycle. When blank_i then falls, drive_o shows the final loaded pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock; data is taken on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of stages and latches |
| sdata_i | input | 1 | Serial data input |
| strobe_i | input | 1 | High: latches transparent; low: latches hold |
| blank_i | input | 1 | High: all parallel outputs forced low |
| sdata_o | output | 1 | Serial output from the last stage, for cascading |
| drive_o | output | Width | Parallel outputs; bit 0 is the stage nearest sdata_i |

## Verification
A wrong stage shows up on the next core's input or at sdata_o after at most Width further edges, and it shows up on drive_o as soon as the strobe opens the latches. A latch that leaks while strobe is low changes drive_o within the same cycle as the shift that disturbs it. For that reason drive_o is compared with the model after every shift, not only after each strobe. A blanking gate that corrupts the latches is exposed the moment blank_i is released, because drive_o must then match the data captured before or during blanking.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic {
    LAT_HOLD = 1'b0,
    LAT_PASS = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/sld_shift_reg.sv
module sld_shift_reg #(
  parameter int Width = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  output logic [Width-1:0] stages_o,
  output logic             sdata_o
);
  localparam int LastIdx = Width - 1;

  logic [Width-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[LastIdx-1:0], sdata_i};
  end

  assign stages_o = stage_q;
  assign sdata_o  = stage_q[LastIdx];
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank
  import sld_pkg::*;
#(
  parameter int Width = 32
) (
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [Width-1:0] d_i,
  output logic [Width-1:0] q_o
);
  lat_mode_e        mode;
  logic [Width-1:0] lat_q;

  assign mode = strobe_i ? LAT_PASS : LAT_HOLD;

  // level-sensitive on purpose: transparent for the whole strobe-high window
  always_latch begin
    if (!rst_ni)               lat_q <= '0;
    else if (mode == LAT_PASS) lat_q <= d_i;
  end

  assign q_o = lat_q;
endmodule

// File: rtl/sld_blank_gate.sv
module sld_blank_gate #(
  parameter int Width = 32
) (
  input  logic             blank_i,
  input  logic [Width-1:0] d_i,
  output logic [Width-1:0] q_o
);
  for (genvar b = 0; b < Width; b++) begin : g_bit
    assign q_o[b] = d_i[b] & ~blank_i;
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int Width = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             strobe_i,
  input  logic             blank_i,
  output logic             sdata_o,
  output logic [Width-1:0] drive_o
);
  localparam int LastIdx = Width - 1;

  logic [Width-1:0] stages;
  logic [Width-1:0] latched;

  sld_shift_reg #(.Width(Width)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (sdata_i),
    .stages_o (stages),
    .sdata_o  (sdata_o)
  );

  sld_latch_bank #(.Width(Width)) i_latch (
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .d_i      (stages),
    .q_o      (latched)
  );

  sld_blank_gate #(.Width(Width)) i_blank (
    .blank_i (blank_i),
    .d_i     (latched),
    .q_o     (drive_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (drive_o == '0 && sdata_o == 1'b0)); // R1

  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !blank_i && $past(rst_ni)) |-> drive_o[0] == $past(sdata_i)); // R2

  AST_CHAIN_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !blank_i) |-> drive_o[LastIdx] == sdata_o); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> latched == stages); // R4

  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> drive_o == '0); // R6
endmodule

// File: tb/test_serial_latch_driver.sv
module test_serial_latch_driver;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W  = 32;
  localparam int CW = 2 * W;

  logic osc = 1'b0;
  logic clk_en = 1'b0;
  logic clk_i;
  logic rst_ni, sdata_i, strobe_i, blank_i;
  logic sd_mid, sd_out;
  logic [W-1:0] drv_a, drv_b;

  logic [CW-1:0] reg_m, lat_m;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 osc = ~osc;
  assign clk_i = osc & clk_en;

  serial_latch_driver #(.Width(W)) i_serial_latch_driver (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sdata_i), .strobe_i(strobe_i),
    .blank_i(blank_i), .sdata_o(sd_mid), .drive_o(drv_a));

  serial_latch_driver #(.Width(W)) i_serial_latch_driver_tail (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sd_mid), .strobe_i(strobe_i),
    .blank_i(blank_i), .sdata_o(sd_out), .drive_o(drv_b));

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    check(tag, {drv_b, drv_a}, blank_i ? '0 : lat_m);
  endtask

  task automatic shift_bit(input logic b, input string tag);
    sdata_i = b;
    clk_en  = 1'b1;
    @(posedge osc);
    reg_m = {reg_m[CW-2:0], b};
    if (strobe_i) lat_m = reg_m;
    @(negedge osc);
    clk_en = 1'b0;
    #0.5;
    check("R3 serial chain", {62'd0, sd_out, sd_mid}, {62'd0, reg_m[CW-1], reg_m[W-1]});
    check_out(tag);
  endtask

  task automatic load(input logic [CW-1:0] pat, input string tag);
    for (int i = CW - 1; i >= 0; i--) shift_bit(pat[i], tag);
  endtask

  task automatic strobe_pulse(input string tag);
    @(negedge osc);
    strobe_i = 1'b1;
    lat_m = reg_m;
    #0.5;
    check_out(tag);
    @(negedge osc);
    strobe_i = 1'b0;
    #0.5;
    check_out(tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (40000) @(posedge osc);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] p1, p2, p3;
    rst_ni = 1'b0; sdata_i = 1'b0; strobe_i = 1'b0; blank_i = 1'b0;
    reg_m = '0; lat_m = '0;
    p1 = 64'hF0E1_D2C3_B4A5_9687;
    p2 = 64'h5A5A_0FF0_3C3C_A5A5;
    p3 = 64'h8000_0001_7FFE_C003;
    repeat (3) @(negedge osc);
    // R1: reset state
    check("R1 reset outputs", {drv_b, drv_a}, '0);
    check("R1 reset serial out", {62'd0, sd_out, sd_mid}, '0);
    rst_ni = 1'b1;
    @(negedge osc);

    // R5: load with strobe low, outputs hold the reset contents
    load(p1, "R5 hold during shift");
    check("R2 full load", reg_m, p1);
    strobe_pulse("R2 R4 strobe capture");

    // R5: new load must not disturb latched p1
    load(p2, "R5 hold after capture");

    // R6, R7: blanking over held data
    @(negedge osc);
    blank_i = 1'b1;
    #0.5;
    check("R6 blank forces zero", {drv_b, drv_a}, '0);
    @(negedge osc);
    blank_i = 1'b0;
    #0.5;
    check("R7 unblank shows latch", {drv_b, drv_a}, p1);

    // R7: strobe during blanking
    @(negedge osc);
    blank_i = 1'b1;
    strobe_pulse("R6 strobe under blank");
    @(negedge osc);
    blank_i = 1'b0;
    #0.5;
    check("R7 latch loaded under blank", {drv_b, drv_a}, p2);

    // R8: bypass mode with blanking during load
    @(negedge osc);
    blank_i = 1'b1;
    strobe_i = 1'b1;
    lat_m = reg_m;
    load(p3, "R8 bypass load hidden");
    @(negedge osc);
    blank_i = 1'b0;
    #0.5;
    check("R8 bypass final pattern", {drv_b, drv_a}, p3);

    // R4: transparent follow while strobe high and not blanked
    for (int i = 0; i < 12; i++) shift_bit(i[0] ^ i[2], "R4 transparent follow");
    @(negedge osc);
    strobe_i = 1'b0;

    // R2: several patterns, captured and compared on both cores
    for (int k = 0; k < 4; k++) begin
      logic [CW-1:0] pat;
      pat = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ (64'h1 << (k * 13));
      load(pat, "R5 hold sweep");
      strobe_pulse("R2 pattern capture");
      check("R2 pattern match", {drv_b, drv_a}, pat);
    end

    // R1: reset in the middle of operation
    @(negedge osc);
    rst_ni = 1'b0;
    reg_m = '0;
    lat_m = '0;
    #0.5;
    check("R1 mid-run reset outputs", {drv_b, drv_a}, '0);
    check("R1 mid-run reset serial", {62'd0, sd_out, sd_mid}, '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule